// File: doc/BRIEF.md
# Saturating Event Counter with Snapshot

This block counts single-cycle event pulses in a running counter that stops at its all-ones value rather than wrapping. Software never sees the running counter directly. It sees a holding register instead, which is loaded when an update request rises from low to high. On that edge the running count moves into the holding register and the counter starts a new interval in the same clock. An event that lands on the transfer edge is credited to the new interval, so no event is lost.

A status output reports progress. It drops when a transfer starts and rises again two clocks later. A zero indicator follows "holding register equals zero", but it is pulled low for exactly one clock at the start of each transfer.

Counting can be switched off with an enable input. While disabled, the counter holds its value, but transfers still run and still restart it. A data-path reset clears both the counter and the holding register and cancels any transfer in progress. Two transfers in a row with no events between them leave both cleared.

Top module: `evcnt_snapshot`

## Requirements
- R1: After the global reset `rst`, `snap_q` is 0, `upd_done` is 1 and `zero_flag` is 1.
- R2: With `cnt_en` high, every clock edge that samples `event_in` high adds one to the running count. The count becomes visible in `snap_q` at the next transfer.
- R3: The running count saturates at 2^WIDTH-1 and never wraps.
- R4: A transfer starts only on a clock where `upd_req` is high and was low on the previous clock. Holding `upd_req` high starts no further transfer.
- R5: On the edge that detects a rise, `snap_q` takes the running count and `upd_done` goes low. `upd_done` stays low for two clocks and then returns to 1.
- R6: `zero_flag` is low for exactly the first clock of a transfer. From the second clock on, it equals (`snap_q` == 0).
- R7: An event sampled on the transfer edge is counted as the first event of the new interval.
- R8: While `cnt_en` is low, events are ignored and the count holds. A transfer still copies the held count and restarts the counter at 0.
- R9: A rise of `upd_req` detected during the last busy clock of a transfer is ignored and is not queued.
- R10: Two transfers back to back, with no counted events between them, leave `snap_q` at 0 and `zero_flag` at 1.
- R11: While `dp_rst` is high, the counter and `snap_q` are cleared, any transfer is cancelled, and `upd_done` and `zero_flag` are 1. A request that is already high when `dp_rst` is released does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Global synchronous reset, active high |
| dp_rst | input | 1 | Data-path clear, active high |
| cnt_en | input | 1 | Counting enable; low holds the count |
| event_in | input | 1 | Event pulse, one count per sampled high clock |
| upd_req | input | 1 | Update request; its rising edge starts a transfer |
| snap_q | output | WIDTH | Holding register with the last transferred count |
| upd_done | output | 1 | High when idle, low while a transfer runs |
| zero_flag | output | 1 | High when the holding register is zero, forced low for one transfer clock |

## Verification
The running counter cannot be seen at the ports. A wrong count, a lost edge event, or a wrap past saturation therefore shows up only in `snap_q` at the next transfer, which the bench issues frequently. A fault in the sequencer shows up within two clocks of a request, as a wrong length of the `upd_done` low window or of the `zero_flag` low pulse. The bench compares all three outputs against a behavioural model on every clock. This catches faults in the holding register and the status signals on the clock they occur, rather than at the end of a test section.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ZLOW = 2'd1,
    PH_FIN  = 2'd2
  } xfer_phase_t;
endpackage

// File: rtl/evcnt_edge.sv
module evcnt_edge (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic rise_o
);
  logic req_d;

  // After reset the previous value is taken as high, so a request that is
  // already held high never looks like a fresh edge.
  always_ff @(posedge clk) begin
    if (rst) req_d <= 1'b1;
    else     req_d <= req_i;
  end

  assign rise_o = req_i & ~req_d;

  // R4
  rise_once_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/evcnt_counter.sv
module evcnt_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             ev_i,
  input  logic             restart_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q;
  logic             hit;

  assign hit = en_i & ev_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      cnt_q <= '0;
    else if (restart_i)
      cnt_q <= hit ? {{(WIDTH-1){1'b0}}, 1'b1} : '0;
    else if (hit && cnt_q != MAXV)
      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == MAXV && !clr_i && !restart_i) |=> cnt_q == MAXV);

  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i && !restart_i) |=> $stable(cnt_q));

  // R7
  edge_event_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (restart_i && en_i && ev_i && !clr_i) |=> cnt_q == 1);
endmodule

// File: rtl/evcnt_ctrl.sv
module evcnt_ctrl
  import evcnt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dp_rst_i,
  input  logic             rise_i,
  input  logic [WIDTH-1:0] cnt_i,
  output logic             restart_o,
  output logic [WIDTH-1:0] snap_o,
  output logic             done_o,
  output logic             zero_o
);
  xfer_phase_t      phase;
  logic [WIDTH-1:0] snap_q;
  logic             done_q;
  logic             zero_q;

  assign restart_o = rise_i && (phase == PH_IDLE) && !dp_rst_i;

  always_ff @(posedge clk) begin
    if (rst || dp_rst_i) begin
      phase  <= PH_IDLE;
      snap_q <= '0;
      done_q <= 1'b1;
      zero_q <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: if (restart_o) begin
          snap_q <= cnt_i;
          done_q <= 1'b0;
          zero_q <= 1'b0;
          phase  <= PH_ZLOW;
        end
        PH_ZLOW: begin
          zero_q <= (snap_q == '0);
          phase  <= PH_FIN;
        end
        PH_FIN: begin
          done_q <= 1'b1;
          phase  <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign snap_o = snap_q;
  assign done_o = done_q;
  assign zero_o = zero_q;

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (rst || dp_rst_i)
    (rise_i && phase == PH_IDLE) |=> (!done_o && !zero_o && phase == PH_ZLOW));

  // R6
  zero_restore_chk: assert property (@(posedge clk) disable iff (rst || dp_rst_i)
    (phase == PH_ZLOW) |=> (zero_o == (snap_o == '0)));

  // R9
  no_queue_chk: assert property (@(posedge clk) disable iff (rst || dp_rst_i)
    (phase == PH_FIN) |=> (phase == PH_IDLE && done_o));

  // R11
  dp_clear_chk: assert property (@(posedge clk) disable iff (rst)
    dp_rst_i |=> (snap_o == '0 && done_o && zero_o));
endmodule

// File: rtl/evcnt_snapshot.sv
module evcnt_snapshot #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dp_rst,
  input  logic             cnt_en,
  input  logic             event_in,
  input  logic             upd_req,
  output logic [WIDTH-1:0] snap_q,
  output logic             upd_done,
  output logic             zero_flag
);
  logic             rise;
  logic             restart;
  logic [WIDTH-1:0] cnt;

  evcnt_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .req_i  (upd_req),
    .rise_o (rise)
  );

  evcnt_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (dp_rst),
    .en_i      (cnt_en),
    .ev_i      (event_in),
    .restart_i (restart),
    .cnt_o     (cnt)
  );

  evcnt_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .dp_rst_i  (dp_rst),
    .rise_i    (rise),
    .cnt_i     (cnt),
    .restart_o (restart),
    .snap_o    (snap_q),
    .done_o    (upd_done),
    .zero_o    (zero_flag)
  );
endmodule

// File: tb/tb_evcnt_snapshot.sv
`timescale 1ns/1ps
module tb_evcnt_snapshot;
  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0;
  logic rst = 1, dp_rst = 0, cnt_en = 1, event_in = 0, upd_req = 0;
  logic [W-1:0] snap_q;
  logic upd_done, zero_flag;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit armed = 0;

  // Behavioural reference model state.
  int m_cnt, m_snap, m_ph, m_prev, m_done, m_zero;

  always #10 clk = ~clk;

  evcnt_snapshot #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .dp_rst(dp_rst), .cnt_en(cnt_en),
    .event_in(event_in), .upd_req(upd_req),
    .snap_q(snap_q), .upd_done(upd_done), .zero_flag(zero_flag)
  );

  always @(posedge clk) begin
    automatic bit rise;
    automatic bit hit;
    if (rst) begin
      m_cnt = 0; m_snap = 0; m_ph = 0; m_prev = 1; m_done = 1; m_zero = 1;
    end else begin
      rise   = upd_req && !m_prev;
      m_prev = upd_req;
      hit    = cnt_en && event_in;
      if (dp_rst) begin
        m_cnt = 0; m_snap = 0; m_ph = 0; m_done = 1; m_zero = 1;
      end else if (m_ph == 0 && rise) begin
        m_snap = m_cnt; m_cnt = hit ? 1 : 0;
        m_done = 0; m_zero = 0; m_ph = 1;
      end else begin
        if (hit && m_cnt < MAXV) m_cnt = m_cnt + 1;
        if (m_ph == 1) begin m_zero = (m_snap == 0); m_ph = 2; end
        else if (m_ph == 2) begin m_done = 1; m_ph = 0; end
      end
    end
    armed = 1;
  end

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (armed) begin
    chk({tag, " snap"}, snap_q, m_snap);
    chk({tag, " done"}, upd_done, m_done);
    chk({tag, " zero"}, zero_flag, m_zero);
  end

  task automatic cyc(input bit ev, input bit rq);
    event_in = ev; upd_req = rq;
    @(negedge clk); #1;
  endtask

  task automatic update();
    cyc(0, 1); cyc(0, 0); cyc(0, 0); cyc(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    cyc(0, 0);
    tag = "R1";
    chk("R1 snap", snap_q, 0); chk("R1 done", upd_done, 1); chk("R1 zero", zero_flag, 1);

    tag = "R2";
    repeat (5) cyc(1, 0);
    cyc(0, 1);
    chk("R5 done low first", upd_done, 0);
    chk("R6 zero forced low", zero_flag, 0);
    chk("R2 snap five", snap_q, 5);
    cyc(0, 0);
    chk("R5 done low second", upd_done, 0);
    chk("R6 zero after pulse", zero_flag, 0);
    cyc(0, 0);
    chk("R5 done back", upd_done, 1);

    tag = "R7";
    repeat (3) cyc(1, 0);
    cyc(1, 1);
    chk("R7 first interval", snap_q, 3);
    repeat (4) cyc(1, 0);
    cyc(0, 0);
    update();
    chk("R7 edge event kept", snap_q, 5);

    tag = "R4";
    repeat (2) cyc(1, 0);
    cyc(0, 1);
    repeat (6) cyc(1, 1);
    chk("R4 held high no retrigger", snap_q, 2);
    chk("R4 done idle", upd_done, 1);
    cyc(0, 0);
    update();
    chk("R4 new edge snaps", snap_q, 6);

    tag = "R9";
    repeat (3) cyc(1, 0);
    cyc(0, 1); cyc(0, 0); cyc(0, 1);
    cyc(0, 0);
    repeat (2) cyc(1, 0);
    chk("R9 ignored rise", snap_q, 3);
    chk("R9 done high", upd_done, 1);

    tag = "R8";
    update();
    repeat (3) cyc(1, 0);
    cnt_en = 0;
    repeat (4) cyc(1, 0);
    update();
    chk("R8 held count", snap_q, 3);
    repeat (3) cyc(1, 0);
    update();
    chk("R8 restart while off", snap_q, 0);
    cnt_en = 1;

    tag = "R10";
    repeat (4) cyc(1, 0);
    update();
    update();
    chk("R10 snap cleared", snap_q, 0);
    cyc(0, 1);
    chk("R6 forced low at zero", zero_flag, 0);
    cyc(0, 0);
    chk("R6 zero restored", zero_flag, 1);
    cyc(0, 0); cyc(0, 0);
    chk("R10 zero high", zero_flag, 1);

    tag = "R3";
    repeat (MAXV + 40) cyc(1, 0);
    update();
    chk("R3 saturated", snap_q, MAXV);
    cyc(1, 0);
    update();
    chk("R3 restart after sat", snap_q, 1);

    tag = "R11";
    repeat (4) cyc(1, 0);
    update();
    repeat (3) cyc(1, 0);
    dp_rst = 1;
    cyc(1, 1);
    chk("R11 snap cleared", snap_q, 0);
    chk("R11 done high", upd_done, 1);
    chk("R11 zero high", zero_flag, 1);
    dp_rst = 0;
    cyc(0, 1); cyc(0, 1);
    chk("R11 held request ignored", upd_done, 1);
    cyc(0, 0);
    update();
    chk("R11 counter cleared", snap_q, 0);
    repeat (2) cyc(1, 0);
    cyc(0, 1);
    dp_rst = 1;
    cyc(0, 0);
    dp_rst = 0;
    cyc(0, 0);
    chk("R11 cancel transfer", snap_q, 0);
    chk("R11 cancel done", upd_done, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule